// File: doc/BRIEF.md
# Page Translation Buffer with Fault Reporting

This block holds a small, fully associative set of page translations for 32-bit virtual addresses divided into 4 KB pages. A lookup presents a virtual address. The upper 20 bits, the virtual page number, are compared against every stored entry at once. On a match the block forms the physical address in the same cycle from the stored physical page number and the untouched low 12 bits. One clock later it raises exactly one of three flags: a successful translation, a translation miss, or a write-permission fault.

Misses are not resolved in hardware. Software reacts to the miss flag and installs the entry through a fill port. The fill port targets either an index supplied with the request or the slot named by a free-running replacement counter. That counter never points at the lowest, reserved ("pinned") slots. Every entry carries a valid bit, a write-permission bit, a dirty bit and a referenced bit. The dirty and referenced bits are updated by the lookups themselves. A probe port reads the bookkeeping bits of any slot.

Top module: `tlb_xlate`

## Requirements
- R1: After reset every entry is invalid, with dirty and referenced bits clear. All three result flags are 0, and the replacement counter `randomIdx` holds NUM_ENTRIES-1.
- R2: The lookup splits `lookupVaddr` into a page number in bits 31..12 and an offset in bits 11..0. When a valid entry matches, `physAddr` is {stored physical page, offset} in the same cycle; otherwise `physAddr` is 0.
- R3: A lookup that matches no valid entry drives `missFault` high in the next cycle, with `hitFlag` and `protFault` low. At most one of the three flags is ever high.
- R4: A write lookup (`lookupWrite`=1) that matches an entry whose write-permission bit is 0 drives `protFault` high in the next cycle with `hitFlag` low. The entry's dirty and referenced bits stay unchanged.
- R5: A write lookup that matches a writable entry drives `hitFlag` in the next cycle and sets that entry's dirty bit.
- R6: Every successful translation, read or write, sets the referenced bit of the entry used. Misses and write faults set no referenced bit.
- R7: With `fillEn`=1 and `fillUseRandom`=0, the entry at `fillIndex` is loaded at the clock edge with page, physical page, valid and write-permission values taken from the fill inputs.
- R8: With `fillEn`=1 and `fillUseRandom`=1, the entry at the current `randomIdx` is loaded instead. `randomIdx` decrements by one on every clock. From WIRED (default 2) it wraps to NUM_ENTRIES-1, so it never names a slot below WIRED.
- R9: If several valid entries hold the same page number, the lowest-numbered one supplies the translation and receives the bookkeeping updates.
- R10: A fill clears the dirty and referenced bits of its slot. A fill with `fillValid`=0 removes the entry. When a fill and a lookup update the same slot in one cycle, the fill wins.
- R11: A cycle with `lookupValid`=0 produces no flag in the next cycle and changes no dirty or referenced bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| lookupValid | input | 1 | A lookup is presented this cycle |
| lookupWrite | input | 1 | The lookup is a store access |
| lookupVaddr | input | 32 | Virtual address of the lookup |
| physAddr | output | 32 | Translated address, combinational; 0 when no entry matches |
| hitFlag | output | 1 | Registered: previous lookup translated successfully |
| missFault | output | 1 | Registered: previous lookup found no entry |
| protFault | output | 1 | Registered: previous lookup was a write to a read-only page |
| fillEn | input | 1 | Load an entry at this clock edge |
| fillUseRandom | input | 1 | 1: target slot is randomIdx; 0: target slot is fillIndex |
| fillIndex | input | 4 | Explicit target slot |
| fillVpn | input | 20 | Page number stored as the tag |
| fillPpn | input | 20 | Physical page number stored |
| fillValid | input | 1 | Valid bit written |
| fillWritable | input | 1 | Write-permission bit written |
| randomIdx | output | 4 | Current replacement counter value |
| probeIdx | input | 4 | Slot whose bookkeeping bits are shown |
| probeValid | output | 1 | Valid bit of the probed slot |
| probeDirty | output | 1 | Dirty bit of the probed slot |
| probeRef | output | 1 | Referenced bit of the probed slot |

## Verification
The properties check several rules on every cycle. The three flags are mutually exclusive and stay silent after an idle cycle. A permission fault always traces back to a write lookup. The replacement counter follows its decrement-and-wrap path without entering the pinned slots. Any translated address keeps the offset bits of the request. Whether the correct physical page comes out, which of several duplicate entries wins, and how the dirty and referenced bits evolve depend on the stored contents. Only the bench's reference model can show these, as it follows fills, collisions between fills and lookups, and invalidations.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  // Strobes sent from the control to the entry datapath each cycle.
  typedef struct packed {
    logic fillWe;    // load the slot named by fillSlot
    logic touchWe;   // mark the slot named by touchSlot as referenced
    logic setDirty;  // together with touchWe: also mark it modified
  } tlbStrobe_t;
endpackage

// File: rtl/tlb_datapath.sv
module tlb_datapath
  import tlb_pkg::*;
#(
  parameter int NUM_ENTRIES = 16,
  parameter int VPN_W       = 20,
  parameter int PPN_W       = 20,
  parameter int OFF_W       = 12,
  parameter int IDX_W       = $clog2(NUM_ENTRIES)
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  tlbStrobe_t             strobe,
  input  logic [IDX_W-1:0]       fillSlot,
  input  logic [IDX_W-1:0]       touchSlot,
  input  logic [VPN_W-1:0]       fillVpn,
  input  logic [PPN_W-1:0]       fillPpn,
  input  logic                   fillValid,
  input  logic                   fillWritable,
  input  logic [VPN_W-1:0]       lookupVpn,
  input  logic [OFF_W-1:0]       lookupOffset,
  input  logic [IDX_W-1:0]       probeIdx,
  output logic                   anyHit,
  output logic [IDX_W-1:0]       hitSlot,
  output logic                   hitWritable,
  output logic [PPN_W+OFF_W-1:0] physAddr,
  output logic                   probeValid,
  output logic                   probeDirty,
  output logic                   probeRef
);
  logic [NUM_ENTRIES-1:0] entValid, entWr, entDirty, entRef;
  logic [VPN_W-1:0]       entTag [NUM_ENTRIES];
  logic [PPN_W-1:0]       entPpn [NUM_ENTRIES];
  logic [NUM_ENTRIES-1:0] matchVec;

  // One comparator per slot, all in parallel.
  for (genvar i = 0; i < NUM_ENTRIES; i++) begin : g_cmp
    assign matchVec[i] = entValid[i] && (entTag[i] == lookupVpn);
  end

  // Lowest-numbered match wins: scan downwards so the last hit written is the smallest.
  always_comb begin
    hitSlot = '0;
    for (int i = NUM_ENTRIES - 1; i >= 0; i--) begin
      if (matchVec[i]) hitSlot = IDX_W'(i);
    end
  end

  assign anyHit      = |matchVec;
  assign hitWritable = entWr[hitSlot];
  assign physAddr    = anyHit ? {entPpn[hitSlot], lookupOffset} : '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      entValid <= '0;
      entWr    <= '0;
      entDirty <= '0;
      entRef   <= '0;
      for (int i = 0; i < NUM_ENTRIES; i++) begin
        entTag[i] <= '0;
        entPpn[i] <= '0;
      end
    end else begin
      for (int i = 0; i < NUM_ENTRIES; i++) begin
        if (strobe.fillWe && fillSlot == IDX_W'(i)) begin
          entValid[i] <= fillValid;
          entWr[i]    <= fillWritable;
          entTag[i]   <= fillVpn;
          entPpn[i]   <= fillPpn;
          entDirty[i] <= 1'b0;
          entRef[i]   <= 1'b0;
        end else if (strobe.touchWe && touchSlot == IDX_W'(i)) begin
          entRef[i] <= 1'b1;
          if (strobe.setDirty) entDirty[i] <= 1'b1;
        end
      end
    end
  end

  assign probeValid = entValid[probeIdx];
  assign probeDirty = entDirty[probeIdx];
  assign probeRef   = entRef[probeIdx];
endmodule

// File: rtl/tlb_control.sv
module tlb_control
  import tlb_pkg::*;
#(
  parameter int NUM_ENTRIES = 16,
  parameter int WIRED       = 2,
  parameter int IDX_W       = $clog2(NUM_ENTRIES)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             lookupValid,
  input  logic             lookupWrite,
  input  logic             anyHit,
  input  logic [IDX_W-1:0] hitSlot,
  input  logic             hitWritable,
  input  logic             fillEn,
  input  logic             fillUseRandom,
  input  logic [IDX_W-1:0] fillIndex,
  output tlbStrobe_t       strobe,
  output logic [IDX_W-1:0] fillSlot,
  output logic [IDX_W-1:0] touchSlot,
  output logic [IDX_W-1:0] randomIdx,
  output logic             hitFlag,
  output logic             missFault,
  output logic             protFault
);
  localparam logic [IDX_W-1:0] RAND_TOP = IDX_W'(NUM_ENTRIES - 1);
  localparam logic [IDX_W-1:0] RAND_LOW = IDX_W'(WIRED);

  logic denied, granted;

  assign denied  = lookupValid && anyHit && lookupWrite && !hitWritable;
  assign granted = lookupValid && anyHit && !denied;

  always_comb begin
    strobe.fillWe   = fillEn;
    strobe.touchWe  = granted;
    strobe.setDirty = lookupWrite;
  end

  assign fillSlot  = fillUseRandom ? randomIdx : fillIndex;
  assign touchSlot = hitSlot;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      randomIdx <= RAND_TOP;
      hitFlag   <= 1'b0;
      missFault <= 1'b0;
      protFault <= 1'b0;
    end else begin
      randomIdx <= (randomIdx == RAND_LOW) ? RAND_TOP : randomIdx - 1'b1;
      hitFlag   <= granted;
      missFault <= lookupValid && !anyHit;
      protFault <= denied;
    end
  end
endmodule

// File: rtl/tlb_xlate.sv
module tlb_xlate
  import tlb_pkg::*;
#(
  parameter int NUM_ENTRIES = 16,
  parameter int WIRED       = 2,
  parameter int VA_W        = 32,
  parameter int OFF_W       = 12
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic                           lookupValid,
  input  logic                           lookupWrite,
  input  logic [VA_W-1:0]                lookupVaddr,
  output logic [VA_W-1:0]                physAddr,
  output logic                           hitFlag,
  output logic                           missFault,
  output logic                           protFault,
  input  logic                           fillEn,
  input  logic                           fillUseRandom,
  input  logic [$clog2(NUM_ENTRIES)-1:0] fillIndex,
  input  logic [VA_W-OFF_W-1:0]          fillVpn,
  input  logic [VA_W-OFF_W-1:0]          fillPpn,
  input  logic                           fillValid,
  input  logic                           fillWritable,
  output logic [$clog2(NUM_ENTRIES)-1:0] randomIdx,
  input  logic [$clog2(NUM_ENTRIES)-1:0] probeIdx,
  output logic                           probeValid,
  output logic                           probeDirty,
  output logic                           probeRef
);
  localparam int VPN_W = VA_W - OFF_W;
  localparam int IDX_W = $clog2(NUM_ENTRIES);

  tlbStrobe_t       strobe;
  logic [IDX_W-1:0] fillSlot, touchSlot, hitSlot;
  logic             anyHit, hitWritable;

  tlb_control #(.NUM_ENTRIES(NUM_ENTRIES), .WIRED(WIRED), .IDX_W(IDX_W)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .lookupValid(lookupValid), .lookupWrite(lookupWrite),
    .anyHit(anyHit), .hitSlot(hitSlot), .hitWritable(hitWritable),
    .fillEn(fillEn), .fillUseRandom(fillUseRandom), .fillIndex(fillIndex),
    .strobe(strobe), .fillSlot(fillSlot), .touchSlot(touchSlot),
    .randomIdx(randomIdx), .hitFlag(hitFlag), .missFault(missFault), .protFault(protFault)
  );

  tlb_datapath #(.NUM_ENTRIES(NUM_ENTRIES), .VPN_W(VPN_W), .PPN_W(VPN_W),
                 .OFF_W(OFF_W), .IDX_W(IDX_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .fillSlot(fillSlot), .touchSlot(touchSlot),
    .fillVpn(fillVpn), .fillPpn(fillPpn), .fillValid(fillValid), .fillWritable(fillWritable),
    .lookupVpn(lookupVaddr[VA_W-1:OFF_W]), .lookupOffset(lookupVaddr[OFF_W-1:0]),
    .probeIdx(probeIdx),
    .anyHit(anyHit), .hitSlot(hitSlot), .hitWritable(hitWritable), .physAddr(physAddr),
    .probeValid(probeValid), .probeDirty(probeDirty), .probeRef(probeRef)
  );
endmodule

// File: rtl/tlb_xlate_checker.sv
module tlb_xlate_checker #(
  parameter int NUM_ENTRIES = 16,
  parameter int WIRED       = 2,
  parameter int VA_W        = 32,
  parameter int OFF_W       = 12
) (
  input logic                           clk,
  input logic                           rstN,
  input logic                           lookupValid,
  input logic                           lookupWrite,
  input logic [VA_W-1:0]                lookupVaddr,
  input logic [VA_W-1:0]                physAddr,
  input logic                           hitFlag,
  input logic                           missFault,
  input logic                           protFault,
  input logic [$clog2(NUM_ENTRIES)-1:0] randomIdx
);
  localparam int IDX_W = $clog2(NUM_ENTRIES);
  localparam logic [IDX_W-1:0] RAND_TOP = IDX_W'(NUM_ENTRIES - 1);
  localparam logic [IDX_W-1:0] RAND_LOW = IDX_W'(WIRED);

  a_r3_one_flag: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({hitFlag, missFault, protFault}));

  a_r11_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !lookupValid |=> !(hitFlag || missFault || protFault));

  a_r4_fault_from_write: assert property (@(posedge clk) disable iff (!rstN)
    protFault |-> $past(lookupValid && lookupWrite));

  a_r8_floor: assert property (@(posedge clk) disable iff (!rstN)
    randomIdx >= RAND_LOW);

  a_r8_step: assert property (@(posedge clk) disable iff (!rstN)
    (randomIdx != RAND_LOW) |=> (randomIdx == $past(randomIdx) - 1'b1));

  a_r8_wrap: assert property (@(posedge clk) disable iff (!rstN)
    (randomIdx == RAND_LOW) |=> (randomIdx == RAND_TOP));

  a_r2_offset_kept: assert property (@(posedge clk) disable iff (!rstN)
    (physAddr == '0) || (physAddr[OFF_W-1:0] == lookupVaddr[OFF_W-1:0]));
endmodule

bind tlb_xlate tlb_xlate_checker #(
  .NUM_ENTRIES(NUM_ENTRIES), .WIRED(WIRED), .VA_W(VA_W), .OFF_W(OFF_W)
) chk (
  .clk(clk), .rstN(rstN), .lookupValid(lookupValid), .lookupWrite(lookupWrite),
  .lookupVaddr(lookupVaddr), .physAddr(physAddr), .hitFlag(hitFlag),
  .missFault(missFault), .protFault(protFault), .randomIdx(randomIdx)
);

// File: tb/tlb_xlate_test.sv
module tlb_xlate_test;
  localparam int CLK_PERIOD = 10;
  localparam int N = 16;
  localparam int WIRED = 2;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        lookupValid = 1'b0, lookupWrite = 1'b0;
  logic [31:0] lookupVaddr = '0;
  logic [31:0] physAddr;
  logic        hitFlag, missFault, protFault;
  logic        fillEn = 1'b0, fillUseRandom = 1'b0, fillValid = 1'b0, fillWritable = 1'b0;
  logic [3:0]  fillIndex = '0, probeIdx = '0;
  logic [19:0] fillVpn = '0, fillPpn = '0;
  logic [3:0]  randomIdx;
  logic        probeValid, probeDirty, probeRef;

  int nCmp = 0, nBad = 0;
  bit finished = 0;

  // Reference model state
  bit          mValid[N], mWr[N], mDirty[N], mRef[N];
  logic [19:0] mTag[N], mPpn[N];
  int          mRand;

  always #(CLK_PERIOD/2) clk = ~clk;

  tlb_xlate uut (
    .clk(clk), .rstN(rstN), .lookupValid(lookupValid), .lookupWrite(lookupWrite),
    .lookupVaddr(lookupVaddr), .physAddr(physAddr), .hitFlag(hitFlag),
    .missFault(missFault), .protFault(protFault), .fillEn(fillEn),
    .fillUseRandom(fillUseRandom), .fillIndex(fillIndex), .fillVpn(fillVpn),
    .fillPpn(fillPpn), .fillValid(fillValid), .fillWritable(fillWritable),
    .randomIdx(randomIdx), .probeIdx(probeIdx), .probeValid(probeValid),
    .probeDirty(probeDirty), .probeRef(probeRef)
  );

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    nCmp++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic checkProbe(string tag, int idx);
    chk(tag, "probeValid", 32'(probeValid), 32'(mValid[idx]));
    chk(tag, "probeDirty", 32'(probeDirty), 32'(mDirty[idx]));
    chk(tag, "probeRef",   32'(probeRef),   32'(mRef[idx]));
  endtask

  // One clock: drive at negedge, check combinational output, step the model, check after the edge.
  task automatic cycle(string tag, bit lv, bit lw, logic [31:0] va,
                       bit fe, bit fr, int fi, logic [19:0] fvpn, logic [19:0] fppn,
                       bit fv, bit fw, int pidx);
    int sel = -1;
    int slot;
    bit eHit, eMiss, eProt;
    logic [31:0] ePhys;
    lookupValid = lv; lookupWrite = lw; lookupVaddr = va;
    fillEn = fe; fillUseRandom = fr; fillIndex = 4'(fi);
    fillVpn = fvpn; fillPpn = fppn; fillValid = fv; fillWritable = fw;
    probeIdx = 4'(pidx);
    #1;
    for (int i = 0; i < N; i++)
      if (sel < 0 && mValid[i] && mTag[i] == va[31:12]) sel = i;
    ePhys = (sel >= 0) ? {mPpn[sel], va[11:0]} : 32'h0;
    chk(tag, "physAddr", physAddr, ePhys);
    eMiss = lv && sel < 0;
    eProt = lv && sel >= 0 && lw && !mWr[sel];
    eHit  = lv && sel >= 0 && !eProt;
    if (eHit) begin
      mRef[sel] = 1;
      if (lw) mDirty[sel] = 1;
    end
    if (fe) begin
      slot = fr ? mRand : fi;
      mValid[slot] = fv; mWr[slot] = fw; mTag[slot] = fvpn; mPpn[slot] = fppn;
      mDirty[slot] = 0;  mRef[slot] = 0;
    end
    mRand = (mRand == WIRED) ? N - 1 : mRand - 1;
    @(posedge clk);
    #1;
    chk(tag, "hitFlag",   32'(hitFlag),   32'(eHit));
    chk(tag, "missFault", 32'(missFault), 32'(eMiss));
    chk(tag, "protFault", 32'(protFault), 32'(eProt));
    chk(tag, "randomIdx", 32'(randomIdx), 32'(mRand));
    checkProbe(tag, pidx);
    @(negedge clk);
  endtask

  task automatic look(string tag, bit lw, logic [31:0] va, int pidx);
    cycle(tag, 1, lw, va, 0, 0, 0, 20'h0, 20'h0, 0, 0, pidx);
  endtask

  task automatic fill(string tag, bit fr, int fi, logic [19:0] vpn, logic [19:0] ppn,
                      bit fv, bit fw, int pidx);
    cycle(tag, 0, 0, 32'h0, 1, fr, fi, vpn, ppn, fv, fw, pidx);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      nBad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < N; i++) begin
      mValid[i] = 0; mWr[i] = 0; mDirty[i] = 0; mRef[i] = 0; mTag[i] = '0; mPpn[i] = '0;
    end
    mRand = N - 1;
    repeat (3) @(negedge clk);
    // R1: reset state visible while reset is held
    chk("R1", "hitFlag", 32'(hitFlag), 0);
    chk("R1", "missFault", 32'(missFault), 0);
    chk("R1", "protFault", 32'(protFault), 0);
    chk("R1", "randomIdx", 32'(randomIdx), N - 1);
    for (int i = 0; i < N; i++) begin
      probeIdx = 4'(i);
      #1;
      checkProbe("R1", i);
    end
    rstN = 1'b1;

    look("R3", 0, 32'h1234_5678, 0);                           // empty: miss
    fill("R7", 0, 3, 20'h12345, 20'hABCDE, 1, 0, 3);           // explicit slot, read-only
    look("R2", 0, 32'h1234_5678, 3);                           // read hit, translation
    look("R6", 0, 32'h1234_5ABC, 3);                           // ref stays set
    look("R4", 1, 32'h1234_5000, 3);                           // write to read-only
    fill("R10", 0, 3, 20'h12345, 20'hABCDE, 1, 0, 3);          // refill clears ref
    look("R4", 1, 32'h1234_5FFF, 3);                           // fault leaves ref clear
    fill("R7", 0, 5, 20'h00400, 20'h00077, 1, 1, 5);           // writable slot
    look("R5", 1, 32'h0040_0010, 5);                           // dirty + ref set
    look("R3", 0, 32'h0040_1010, 5);                           // neighbour page misses
    fill("R9", 0, 9, 20'h00400, 20'h00099, 1, 1, 9);           // duplicate tag higher slot
    look("R9", 0, 32'h0040_0234, 9);                           // slot 5 wins, 9 untouched
    fill("R10", 0, 5, 20'h00400, 20'h00077, 0, 1, 5);          // invalidate slot 5
    look("R10", 1, 32'h0040_0234, 9);                          // now slot 9 serves
    // R10: lookup and fill on the same slot in one cycle: fill wins
    cycle("R10", 1, 1, 32'h0040_0004, 1, 0, 9, 20'h00400, 20'h00055, 1, 1, 9);
    look("R10", 0, 32'h0040_0008, 9);
    // R8: fills at the replacement counter
    fill("R8", 1, 0, 20'h00007, 20'h00008, 1, 1, 0);
    look("R8", 0, 32'h0000_7123, 0);
    fill("R8", 1, 0, 20'hFFFFF, 20'h00001, 1, 0, 0);
    look("R8", 0, 32'hFFFF_F001, 0);
    // R11 / R8: idle cycles let the counter wrap; bits must stay put
    for (int k = 0; k < 2 * N; k++)
      cycle("R11", 0, 1, 32'h0040_0000, 0, 0, 0, 20'h0, 20'h0, 0, 0, k % N);
    look("R2", 0, 32'h0000_0000, 0);                           // page 0 never filled
    look("R5", 1, 32'h0000_7FFF, 0);

    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end
endmodule